// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small, set-associative cache of page table entries sitting next to an address translation unit. A requester presents a virtual page number. One cycle later the block answers with a hit flag and, on a hit, the physical page number and the access-permission bits that were cached for that page. No page table read is needed on a hit. On a miss the requester fetches the entry from the page table in memory and writes it back through the fill port. A flush input drops every cached entry at once, for example after the page tables change.

The virtual page number is split in two. Its low `SET_BITS` bits pick one of `2**SET_BITS` sets. The remaining upper bits are kept as the tag. Each set holds `WAYS` lines, two by default. Each line stores a valid flag, the tag, the physical page number and the permission bits. When a set is full, a per-set pointer to the least recently used line chooses which line a fill replaces. Both hits and fills move this pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset, and again after any later reset, `rsp_valid` is low and every lookup misses until a fill is made.
- R2: A lookup is accepted in a cycle where `lk_valid` is high. Its answer appears on `rsp_valid`/`rsp_hit`/`rsp_ppn`/`rsp_perm` in the following cycle only, and `rsp_valid` is low in any cycle that does not follow an accepted lookup.
- R3: The set is `vpn[SET_BITS-1:0]` and the tag is `vpn[VPN_W-1:SET_BITS]`. An entry hits only for the exact page number it was filled with. The same tag in another set misses, and another tag in the same set misses.
- R4: A hit returns the physical page number and the 4-bit permission field exactly as they were given on the fill port.
- R5: When no valid line in the indexed set has a matching tag, `rsp_hit` is low and `rsp_ppn` and `rsp_perm` read zero.
- R6: A fill of a new page into a set that still has an invalid line uses that line, and the entries already in the set stay cached.
- R7: A fill of a new page into a full set replaces the line used least recently, where both a hit and a fill count as a use of a line.
- R8: A fill whose page number already hits a valid line overwrites that line, so a later lookup returns the newest entry.
- R9: A flush invalidates every line at the next clock edge. A lookup answered in the cycle where flush is high reports a miss, and a fill presented in that same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| rsp_valid | output | 1 | Answer to the lookup of the previous cycle |
| rsp_hit | output | 1 | Lookup found a valid matching line |
| rsp_ppn | output | PPN_W | Cached physical page number (zero on miss) |
| rsp_perm | output | PERM_W | Cached permission bits (zero on miss) |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | VPN_W | Page number of the entry being installed |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_perm | input | PERM_W | Permission bits to install |
| flush | input | 1 | Invalidate all lines |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that a hit never occurs without a response;
- that a miss returns zero data;
- that at most one line matches;
- that no hit occurs in or just after a flush cycle;
- that a fill and a lookup of the same page in the same cycle give a hit with the filled data.

Some behaviours need a history of several operations and are shown only by the bench's scenarios:
- which line the least-recently-used pointer evicts after a mix of hits and fills;
- that a fill goes into a free line first;
- that a set is isolated from its neighbours;
- that a refill of the same page overwrites its line instead of leaving a stale copy.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  parameter int unsigned DEF_VPN_W    = 16;
  parameter int unsigned DEF_PPN_W    = 12;
  parameter int unsigned DEF_SET_BITS = 2;
  parameter int unsigned DEF_WAYS     = 2;
  parameter int unsigned DEF_PERM_W   = 4;

  // Where a fill takes its destination line from.
  typedef enum logic [1:0] {
    SRC_MATCH  = 2'd0,
    SRC_FREE   = 2'd1,
    SRC_VICTIM = 2'd2
  } fill_src_e;

endpackage

// File: rtl/xlat_req_stage.sv
module xlat_req_stage #(
  parameter int unsigned VPN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             req_valid_q,
  output logic [VPN_W-1:0] req_vpn_q
);

  logic [VPN_W-1:0] req_vpn_d;

  // Hold the last page number unless a new request arrives.
  always_comb begin
    req_vpn_d = req_vpn_q;
    if (lk_valid) begin
      req_vpn_d = lk_vpn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid_q <= 1'b0;
      req_vpn_q   <= '0;
    end else begin
      req_valid_q <= lk_valid;
      req_vpn_q   <= req_vpn_d;
    end
  end

endmodule

// File: rtl/xlat_way_store.sv
module xlat_way_store #(
  parameter int unsigned SET_BITS = 2,
  parameter int unsigned TAG_W    = 14,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned SETS    = 1 << SET_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [SET_BITS-1:0] rd_set,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [SET_BITS-1:0] pr_set,
  output logic                pr_valid,
  output logic [TAG_W-1:0]    pr_tag
);

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   valid_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];
  logic              wr_go;

  assign wr_go = wr_en & ~flush;

  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[wr_set] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Tags and payload carry no reset; the valid flags qualify them.
  always_ff @(posedge clk) begin
    if (wr_go) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_data  = data_q[rd_set];
  assign pr_valid = valid_q[pr_set];
  assign pr_tag   = tag_q[pr_set];

endmodule

// File: rtl/xlat_hit_select.sv
module xlat_hit_select #(
  parameter int unsigned WAYS     = 2,
  parameter int unsigned TAG_W    = 14,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                         en,
  input  logic [TAG_W-1:0]             lk_tag,
  input  logic [WAYS-1:0]              way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
  input  logic [WAYS-1:0][DATA_W-1:0]  way_data,
  output logic [WAYS-1:0]              match,
  output logic                         hit,
  output logic [WAY_BITS-1:0]          hit_way,
  output logic [DATA_W-1:0]            data
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = en & way_valid[w] & (way_tag[w] == lk_tag);
  end

  // Lowest matching index wins; data is forced to zero on a miss.
  always_comb begin
    hit     = |match;
    hit_way = '0;
    data    = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit_way = WAY_BITS'(w);
        data    = way_data[w];
      end
    end
  end

endmodule

// File: rtl/xlat_replace.sv
module xlat_replace
  import xlat_pkg::*;
#(
  parameter int unsigned SET_BITS  = 2,
  parameter int unsigned WAYS      = 2,
  parameter int unsigned TAG_W     = 14,
  localparam int unsigned SETS     = 1 << SET_BITS,
  localparam int unsigned WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       touch_en,
  input  logic [SET_BITS-1:0]        touch_set,
  input  logic [WAY_BITS-1:0]        touch_way,
  input  logic                       fill_en,
  input  logic [SET_BITS-1:0]        fill_set,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic [WAYS-1:0]            pr_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] pr_tag,
  output logic [WAY_BITS-1:0]        fill_way
);

  logic [WAY_BITS-1:0] vict_q [SETS];
  logic [WAY_BITS-1:0] vict_d [SETS];
  logic [WAY_BITS-1:0] match_way;
  logic [WAY_BITS-1:0] free_way;
  logic                any_match;
  logic                any_free;
  fill_src_e           src;

  function automatic logic [WAY_BITS-1:0] succ(input logic [WAY_BITS-1:0] w);
    succ = (w == WAY_BITS'(WAYS - 1)) ? '0 : w + 1'b1;
  endfunction

  // Find an existing copy of the page and the first free line.
  always_comb begin
    any_match = 1'b0;
    any_free  = 1'b0;
    match_way = '0;
    free_way  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pr_valid[w] && (pr_tag[w] == fill_tag)) begin
        any_match = 1'b1;
        match_way = WAY_BITS'(w);
      end
      if (!pr_valid[w]) begin
        any_free = 1'b1;
        free_way = WAY_BITS'(w);
      end
    end
  end

  always_comb begin
    if (any_match)     src = SRC_MATCH;
    else if (any_free) src = SRC_FREE;
    else               src = SRC_VICTIM;
  end

  always_comb begin
    case (src)
      SRC_MATCH: fill_way = match_way;
      SRC_FREE:  fill_way = free_way;
      default:   fill_way = vict_q[fill_set];
    endcase
  end

  // The pointer names the next line to evict; a fill overrides a hit.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      vict_d[s] = vict_q[s];
    end
    if (touch_en) begin
      vict_d[touch_set] = succ(touch_way);
    end
    if (fill_en) begin
      vict_d[fill_set] = succ(fill_way);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vict_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        vict_q[s] <= vict_d[s];
      end
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W    = DEF_VPN_W,
  parameter int unsigned PPN_W    = DEF_PPN_W,
  parameter int unsigned SET_BITS = DEF_SET_BITS,
  parameter int unsigned WAYS     = DEF_WAYS,
  parameter int unsigned PERM_W   = DEF_PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush
);

  localparam int unsigned TAG_W    = VPN_W - SET_BITS;
  localparam int unsigned DATA_W   = PPN_W + PERM_W;
  localparam int unsigned WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic                       req_valid_q;
  logic [VPN_W-1:0]           req_vpn_q;
  logic [SET_BITS-1:0]        rd_set;
  logic [TAG_W-1:0]           rd_tag_key;
  logic [SET_BITS-1:0]        fl_set;
  logic [TAG_W-1:0]           fl_tag;
  logic                       fill_go;
  logic [WAY_BITS-1:0]        fill_way;
  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][DATA_W-1:0] rd_data;
  logic [WAYS-1:0]            pr_valid;
  logic [WAYS-1:0][TAG_W-1:0] pr_tag;
  logic [WAYS-1:0]            way_match;
  logic                       hit;
  logic [WAY_BITS-1:0]        hit_way;
  logic [DATA_W-1:0]          hit_data;

  xlat_req_stage #(.VPN_W(VPN_W)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_vpn      (lk_vpn),
    .req_valid_q (req_valid_q),
    .req_vpn_q   (req_vpn_q)
  );

  assign rd_set     = req_vpn_q[SET_BITS-1:0];
  assign rd_tag_key = req_vpn_q[VPN_W-1:SET_BITS];
  assign fl_set     = fill_vpn[SET_BITS-1:0];
  assign fl_tag     = fill_vpn[VPN_W-1:SET_BITS];
  assign fill_go    = fill_valid & ~flush;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    xlat_way_store #(
      .SET_BITS (SET_BITS),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_en    (fill_go && (fill_way == WAY_BITS'(w))),
      .wr_set   (fl_set),
      .wr_tag   (fl_tag),
      .wr_data  ({fill_ppn, fill_perm}),
      .rd_set   (rd_set),
      .rd_valid (rd_valid[w]),
      .rd_tag   (rd_tag[w]),
      .rd_data  (rd_data[w]),
      .pr_set   (fl_set),
      .pr_valid (pr_valid[w]),
      .pr_tag   (pr_tag[w])
    );
  end

  xlat_hit_select #(
    .WAYS   (WAYS),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_hit (
    .en        (req_valid_q & ~flush),
    .lk_tag    (rd_tag_key),
    .way_valid (rd_valid),
    .way_tag   (rd_tag),
    .way_data  (rd_data),
    .match     (way_match),
    .hit       (hit),
    .hit_way   (hit_way),
    .data      (hit_data)
  );

  xlat_replace #(
    .SET_BITS (SET_BITS),
    .WAYS     (WAYS),
    .TAG_W    (TAG_W)
  ) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (hit),
    .touch_set (rd_set),
    .touch_way (hit_way),
    .fill_en   (fill_go),
    .fill_set  (fl_set),
    .fill_tag  (fl_tag),
    .pr_valid  (pr_valid),
    .pr_tag    (pr_tag),
    .fill_way  (fill_way)
  );

  assign rsp_valid = req_valid_q;
  assign rsp_hit   = hit;
  assign rsp_ppn   = hit_data[DATA_W-1:PERM_W];
  assign rsp_perm  = hit_data[PERM_W-1:0];

endmodule

// File: rtl/xlat_cache_sva.sv
module xlat_cache_sva #(
  parameter int unsigned VPN_W  = 16,
  parameter int unsigned PPN_W  = 12,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned PERM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              fill_valid,
  input logic [VPN_W-1:0]  fill_vpn,
  input logic [PPN_W-1:0]  fill_ppn,
  input logic [PERM_W-1:0] fill_perm,
  input logic              flush,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [PPN_W-1:0]  rsp_ppn,
  input logic [PERM_W-1:0] rsp_perm,
  input logic [WAYS-1:0]   way_match
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(lk_valid));

  p_hit_has_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_ppn == '0 && rsp_perm == '0));

  p_single_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));

  p_flush_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rsp_hit);

  p_flush_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !rsp_hit);

  p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid && !flush && lk_valid && (lk_vpn == fill_vpn)) && !flush)
      |-> (rsp_hit && rsp_ppn == $past(fill_ppn) && rsp_perm == $past(fill_perm)));

endmodule

bind xlat_cache xlat_cache_sva #(
  .VPN_W  (VPN_W),
  .PPN_W  (PPN_W),
  .WAYS   (WAYS),
  .PERM_W (PERM_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vpn     (lk_vpn),
  .fill_valid (fill_valid),
  .fill_vpn   (fill_vpn),
  .fill_ppn   (fill_ppn),
  .fill_perm  (fill_perm),
  .flush      (flush),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_ppn    (rsp_ppn),
  .rsp_perm   (rsp_perm),
  .way_match  (way_match)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;

  localparam int unsigned VPN_W    = 16;
  localparam int unsigned PPN_W    = 12;
  localparam int unsigned SET_BITS = 2;
  localparam int unsigned WAYS     = 2;
  localparam int unsigned PERM_W   = 4;

  localparam logic OP_LK   = 1'b0;
  localparam logic OP_FILL = 1'b1;

  typedef struct packed {
    logic              op;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
    logic              hit;
    logic [7:0]        req;
  } vec_t;

  // Set 1 pages: A=0011 B=0021 C=0031 D=0041 (tags 4,8,12,16).
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_LK,   16'h0011, 12'h000, 4'h0, 1'b0, 8'd5},  // R5 empty
    '{OP_FILL, 16'h0011, 12'h0A1, 4'hA, 1'b0, 8'd4},
    '{OP_LK,   16'h0011, 12'h0A1, 4'hA, 1'b1, 8'd4},  // R4
    '{OP_FILL, 16'h0021, 12'h0B2, 4'h5, 1'b0, 8'd6},
    '{OP_LK,   16'h0021, 12'h0B2, 4'h5, 1'b1, 8'd6},  // R6
    '{OP_LK,   16'h0011, 12'h0A1, 4'hA, 1'b1, 8'd6},  // R6: B older now
    '{OP_FILL, 16'h0031, 12'h0C3, 4'h3, 1'b0, 8'd7},  // evicts B
    '{OP_LK,   16'h0021, 12'h000, 4'h0, 1'b0, 8'd7},  // R7
    '{OP_LK,   16'h0011, 12'h0A1, 4'hA, 1'b1, 8'd7},
    '{OP_LK,   16'h0031, 12'h0C3, 4'h3, 1'b1, 8'd7},  // A older now
    '{OP_FILL, 16'h0041, 12'h0D4, 4'h6, 1'b0, 8'd7},  // evicts A
    '{OP_LK,   16'h0011, 12'h000, 4'h0, 1'b0, 8'd7},
    '{OP_LK,   16'h0031, 12'h0C3, 4'h3, 1'b1, 8'd7},
    '{OP_LK,   16'h0041, 12'h0D4, 4'h6, 1'b1, 8'd7},
    '{OP_FILL, 16'h0012, 12'h0E5, 4'h9, 1'b0, 8'd3},  // set 2, tag 4
    '{OP_LK,   16'h0012, 12'h0E5, 4'h9, 1'b1, 8'd3},  // R3
    '{OP_LK,   16'h0013, 12'h000, 4'h0, 1'b0, 8'd3},  // same tag, set 3
    '{OP_LK,   16'h0412, 12'h000, 4'h0, 1'b0, 8'd3},  // other tag, set 2
    '{OP_LK,   16'h0011, 12'h000, 4'h0, 1'b0, 8'd3},  // set 1 untouched
    '{OP_FILL, 16'h0053, 12'h111, 4'h1, 1'b0, 8'd8},
    '{OP_FILL, 16'h0053, 12'h222, 4'hF, 1'b0, 8'd8},
    '{OP_LK,   16'h0053, 12'h222, 4'hF, 1'b1, 8'd8}   // R8 newest wins
  };

  logic              clk;
  logic              rst_n;
  logic              lk_valid;
  logic [VPN_W-1:0]  lk_vpn;
  logic              rsp_valid;
  logic              rsp_hit;
  logic [PPN_W-1:0]  rsp_ppn;
  logic [PERM_W-1:0] rsp_perm;
  logic              fill_valid;
  logic [VPN_W-1:0]  fill_vpn;
  logic [PPN_W-1:0]  fill_ppn;
  logic [PERM_W-1:0] fill_perm;
  logic              flush;

  int n_chk;
  int n_fail;
  bit done;

  xlat_cache #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .SET_BITS(SET_BITS), .WAYS(WAYS), .PERM_W(PERM_W)
  ) i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_perm(fill_perm), .flush(flush)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the answer is sampled one falling edge later.
  task automatic do_lookup(input logic [VPN_W-1:0] vpn, input logic eh,
                           input logic [PPN_W-1:0] ep, input logic [PERM_W-1:0] em,
                           input string req);
    logic [31:0] act;
    logic [31:0] exp;
    lk_valid = 1'b1;
    lk_vpn   = vpn;
    @(negedge clk);
    lk_valid = 1'b0;
    act = {15'd0, rsp_hit, rsp_ppn, rsp_perm};
    exp = {15'd0, eh, ep, em};
    chk(act == exp, req, act, exp);
    @(negedge clk);
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] p,
                         input logic [PERM_W-1:0] m);
    fill_valid = 1'b1;
    fill_vpn   = vpn;
    fill_ppn   = p;
    fill_perm  = m;
    @(negedge clk);
    fill_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; flush = 1'b0;
    fill_valid = 1'b0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset
    chk(rsp_valid == 1'b0, "R1 rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk(rsp_hit == 1'b0, "R1 rsp_hit idle", 32'(rsp_hit), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == OP_FILL) begin
        do_fill(VEC[i].vpn, VEC[i].ppn, VEC[i].perm);
      end else begin
        do_lookup(VEC[i].vpn, VEC[i].hit, VEC[i].ppn, VEC[i].perm,
                  $sformatf("R%0d row %0d", VEC[i].req, i));
      end
    end

    // R2: response lives for exactly one cycle
    lk_valid = 1'b1; lk_vpn = 16'h0031;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 response cycle", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 after response", 32'(rsp_valid), 32'd0);

    // R9: flush clears everything
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    do_lookup(16'h0031, 1'b0, '0, '0, "R9 flushed C");
    do_lookup(16'h0041, 1'b0, '0, '0, "R9 flushed D");
    do_lookup(16'h0053, 1'b0, '0, '0, "R9 flushed F");

    // R9: flush in the answer cycle forces a miss
    do_fill(16'h0061, 12'h3AA, 4'h7);
    lk_valid = 1'b1; lk_vpn = 16'h0061;
    @(negedge clk);
    lk_valid = 1'b0; flush = 1'b1;
    #1;
    chk(rsp_hit == 1'b0, "R9 hit during flush", 32'(rsp_hit), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    do_lookup(16'h0061, 1'b0, '0, '0, "R9 gone after flush");

    // R9: fill alongside flush is dropped
    fill_valid = 1'b1; fill_vpn = 16'h0071; fill_ppn = 12'h5C5; fill_perm = 4'h2;
    flush = 1'b1;
    @(negedge clk);
    fill_valid = 1'b0; flush = 1'b0;
    @(negedge clk);
    do_lookup(16'h0071, 1'b0, '0, '0, "R9 fill dropped");

    // R1: a later reset empties the table
    do_fill(16'h0081, 12'h6D6, 4'h8);
    do_lookup(16'h0081, 1'b1, 12'h6D6, 4'h8, "R4 before reset");
    rst_n = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_lookup(16'h0081, 1'b0, '0, '0, "R1 miss after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule